// File: doc/BRIEF.md
# Adaptive Rate Tick Timer

This block paces a set of software or hardware service engines that each advance a bit-level protocol one step per tick. A system-clock prescaler drives a 16-bit down counter. Each time the counter runs out, the block looks at which clients still report work. It then reloads the counter with the shortest period that any of those busy clients needs. When no client is busy, the block masks its own tick output and stops servicing.

A client that has new work pulses the kick input. A kick unmasks the timer and forces the counter to a single count, so the next tick follows one prescaled count later. A kick always wins over a mask decision taken in the same cycle, so a request is never lost.

Counter expiries that occur while the block is masked are recorded in a pending flag. That flag is cleared by an explicit acknowledge or by the next serviced tick. A wrapping counter records how many ticks have been serviced.

Top module: `adaptive_tick_timer`

## Requirements
- R1: The down counter moves one count every PRESC_DIV clock cycles (default 2), so a period of D counts spans D*PRESC_DIV cycles between two expiries.
- R2: Each client's period in microseconds becomes a divisor by shifting it left by 3 bits (8 counts per microsecond). Client 0 (busy_i bit 0) asks for 100 us, which is 800 counts. Client 1 (busy_i bit 1) asks for 20 us, which is 160 counts.
- R3: busy_i is sampled at every serviced expiry. The smallest divisor among the busy clients becomes both the new count and the stored reload value, so with both clients busy the period is 160 counts.
- R4: If no client is busy at a serviced expiry, the block masks itself and leaves the reload value unchanged. The counter keeps running on that old value.
- R5: While masked, tick_o stays low. Each expiry while masked sets pend_o.
- R6: A serviced tick clears pend_o, and so does ack_i in a cycle with no masked expiry.
- R7: A kick (kick_i high for one cycle) clears masked_o, forces the count to 1 and restarts the prescaler. tick_o therefore pulses PRESC_DIV cycles after the kick edge.
- R8: When a kick and an idle mask decision fall in the same cycle, the kick wins: masked_o stays low.
- R9: tick_o is a registered one-cycle pulse in the cycle after a serviced expiry. tick_cnt_o rises by exactly one for each pulse.
- R10: Reset (synchronous, active high) leaves the block masked with pend_o low and tick_cnt_o zero. Count and reload are both 3000, so the first masked expiry sets pend_o 3000*PRESC_DIV cycles after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | NUM_CLIENTS | Per-client work-remaining flags |
| kick_i | input | 1 | One-cycle restart strobe |
| ack_i | input | 1 | Clears the pending flag |
| tick_o | output | 1 | One-cycle service tick |
| masked_o | output | 1 | High while the tick source is masked |
| pend_o | output | 1 | Expiry seen while masked, not yet cleared |
| tick_cnt_o | output | TCNT_W | Count of serviced ticks, wrapping |

## Verification
The embedded properties check every cycle that no tick leaves a masked block without a kick, and that a kick always leaves the block unmasked. They also check that each pulse advances the tick counter by one, that a serviced tick leaves pending clear, that an idle decision keeps the reload value, and that the counter never reaches zero. The actual periods (which divisor wins, the one-count restart after a kick, the 3000-count start-up period) can only be shown by the bench's timed scenarios. The same holds for the reload value that survives masking, which the bench sees through the spacing of later pending events.

// File: rtl/adt_pkg.sv
`timescale 1ns/1ps
package adt_pkg;
  // counts for a period given in microseconds, with 2**shift counts per us
  function automatic int unsigned us_to_counts(int unsigned us, int unsigned shift);
    return us << shift;
  endfunction
endpackage

// File: rtl/adt_prescaler.sv
`timescale 1ns/1ps
module adt_prescaler #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  output logic step_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] pre_q;

  assign step_o = (pre_q == W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || clr_i || step_o) pre_q <= '0;
    else                        pre_q <= pre_q + W'(1);
  end

  generate
    if (DIV > 1) begin : g_spacing
      AST_STEP_SPACING: assert property (@(posedge clk) disable iff (rst)
        step_o |=> !step_o); // R1
    end
  endgenerate
endmodule

// File: rtl/adt_rate_select.sv
`timescale 1ns/1ps
module adt_rate_select #(
  parameter int unsigned N     = 2,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SHIFT = 3,
  parameter int unsigned PERIOD_US [N] = '{default: 100}
) (
  input  logic [N-1:0]     busy_i,
  output logic [CNT_W-1:0] div_o,
  output logic             any_o
);
  logic [CNT_W-1:0] div_tab [N];

  generate
    for (genvar gi = 0; gi < N; gi++) begin : g_div
      assign div_tab[gi] = CNT_W'(adt_pkg::us_to_counts(PERIOD_US[gi], SHIFT));
    end
  endgenerate

  // all ones stands for "nobody busy"
  always_comb begin
    div_o = '1;
    for (int i = 0; i < N; i++) begin
      if (busy_i[i] && (div_tab[i] < div_o)) div_o = div_tab[i];
    end
  end

  assign any_o = |busy_i;
endmodule

// File: rtl/adt_downcount.sv
`timescale 1ns/1ps
module adt_downcount #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned INIT  = 3000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             force_one_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = step_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= CNT_W'(INIT);
    else if (force_one_i) cnt_q <= CNT_W'(1);
    else if (expire_o)    cnt_q <= reload_i;
    else if (step_i)      cnt_q <= cnt_q - CNT_W'(1);
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt_q != '0); // R1
endmodule

// File: rtl/adaptive_tick_timer.sv
`timescale 1ns/1ps
module adaptive_tick_timer #(
  parameter int unsigned NUM_CLIENTS = 2,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned TCNT_W      = 16,
  parameter int unsigned PRESC_DIV   = 2,
  parameter int unsigned US_SHIFT    = 3,
  parameter int unsigned INIT_COUNT  = 3000,
  parameter int unsigned PERIOD_US [NUM_CLIENTS] = '{100, 20}
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_CLIENTS-1:0] busy_i,
  input  logic                   kick_i,
  input  logic                   ack_i,
  output logic                   tick_o,
  output logic                   masked_o,
  output logic                   pend_o,
  output logic [TCNT_W-1:0]      tick_cnt_o
);
  logic             step, expire, serviced, any_busy;
  logic             masked_q, pend_q, tick_q;
  logic [CNT_W-1:0] best_div, reload_q, reload_nxt;
  logic [TCNT_W-1:0] tcnt_q;

  adt_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk(clk), .rst(rst), .clr_i(kick_i), .step_o(step)
  );

  adt_rate_select #(
    .N(NUM_CLIENTS), .CNT_W(CNT_W), .SHIFT(US_SHIFT), .PERIOD_US(PERIOD_US)
  ) u_rate (
    .busy_i(busy_i), .div_o(best_div), .any_o(any_busy)
  );

  adt_downcount #(.CNT_W(CNT_W), .INIT(INIT_COUNT)) u_cnt (
    .clk(clk), .rst(rst), .step_i(step), .force_one_i(kick_i),
    .reload_i(reload_nxt), .expire_o(expire)
  );

  assign serviced   = expire && !masked_q;
  assign reload_nxt = (serviced && any_busy) ? best_div : reload_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      masked_q <= 1'b1;
      pend_q   <= 1'b0;
      tick_q   <= 1'b0;
      tcnt_q   <= '0;
      reload_q <= CNT_W'(INIT_COUNT);
    end else begin
      tick_q <= serviced;
      if (serviced) tcnt_q <= tcnt_q + TCNT_W'(1);
      if (serviced && any_busy) reload_q <= best_div;
      // kick outranks the idle mask decision
      if (kick_i)                     masked_q <= 1'b0;
      else if (serviced && !any_busy) masked_q <= 1'b1;
      if (expire && masked_q)         pend_q <= 1'b1;
      else if (serviced || ack_i)     pend_q <= 1'b0;
    end
  end

  assign tick_o     = tick_q;
  assign masked_o   = masked_q;
  assign pend_o     = pend_q;
  assign tick_cnt_o = tcnt_q;

  AST_MASKED_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (masked_q && !kick_i) |=> !tick_o); // R5
  AST_KICK_UNMASK: assert property (@(posedge clk) disable iff (rst)
    kick_i |=> !masked_o); // R8
  AST_TICK_COUNT: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (tick_cnt_o == $past(tick_cnt_o) + TCNT_W'(1))); // R9
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick_o |-> $stable(tick_cnt_o)); // R9
  AST_TICK_CLEARS_PEND: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> !pend_o); // R6
  AST_IDLE_KEEPS_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (serviced && !any_busy) |=> $stable(reload_q)); // R4
endmodule

// File: tb/adaptive_tick_timer_bench.sv
`timescale 1ns/1ps
module adaptive_tick_timer_bench;
  localparam int P = 2;            // prescale
  localparam int DIV_A = 800;      // 100 us << 3
  localparam int DIV_B = 160;      // 20 us << 3

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] busy_i = 2'b00;
  logic kick_i = 1'b0;
  logic ack_i = 1'b0;
  logic tick_o, masked_o, pend_o;
  logic [15:0] tick_cnt_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string tag_q[$];

  adaptive_tick_timer u_adaptive_tick_timer (
    .clk(clk), .rst(rst), .busy_i(busy_i), .kick_i(kick_i), .ack_i(ack_i),
    .tick_o(tick_o), .masked_o(masked_o), .pend_o(pend_o), .tick_cnt_o(tick_cnt_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
    end
  endtask

  task automatic finish_run();
    if (exp_q.size() != 0) check(1'b0, "R9 pending ticks never seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic expect_tick(input int t, input string tag);
    exp_q.push_back(t);
    tag_q.push_back(tag);
  endtask

  // kick; returns the cycle of the first tick pulse
  task automatic do_kick(output int first);
    @(negedge clk);
    kick_i = 1'b1;
    first = cyc + 1 + P;
    expect_tick(first, "R7 first tick after kick");
    @(negedge clk);
    kick_i = 1'b0;
  endtask

  // monitor: compare every tick pulse against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (exp_q.size() > 0 && cyc > exp_q[0]) begin
        check(1'b0, {tag_q[0], " missed"}, cyc, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      if (tick_o) begin
        if (exp_q.size() == 0) check(1'b0, "R5 unexpected tick", cyc, -1);
        else begin
          int e;
          string tg;
          e = exp_q.pop_front();
          tg = tag_q.pop_front();
          check(cyc == e, tg, cyc, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 60000) begin
      check(1'b0, "watchdog", cyc, 60000);
      finish_run();
    end
  end

  initial begin
    int c0, t;
    repeat (3) @(negedge clk);
    check(tick_o == 0, "R10 reset tick", tick_o, 0);
    check(masked_o == 1, "R10 reset masked", masked_o, 1);
    check(pend_o == 0, "R10 reset pend", pend_o, 0);
    check(tick_cnt_o == 0, "R10 reset count", tick_cnt_o, 0);
    rst = 1'b0;
    c0 = cyc;

    // R10: default 3000-count period seen through pending
    wait_until(c0 + 3000 * P - 1);
    check(pend_o == 0, "R10 pend before default expiry", pend_o, 0);
    @(negedge clk);
    check(pend_o == 1, "R10 pend at default expiry R5", pend_o, 1);
    check(tick_cnt_o == 0, "R5 no ticks while masked", tick_cnt_o, 0);
    ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
    check(pend_o == 0, "R6 ack clears pend", pend_o, 1);

    // scenario: client 1 only -> 160 counts (R2 R3 R1)
    busy_i = 2'b10;
    do_kick(t);
    expect_tick(t + DIV_B * P,     "R2 R3 client1 period");
    expect_tick(t + 2 * DIV_B * P, "R1 R3 client1 period");
    expect_tick(t + 3 * DIV_B * P, "R4 idle tick still serviced");
    wait_until(t + 2 * DIV_B * P + 20);
    busy_i = 2'b00;
    wait_until(t + 3 * DIV_B * P + 5);
    check(masked_o == 1, "R4 idle masks", masked_o, 1);
    check(tick_cnt_o == 4, "R9 tick count", tick_cnt_o, 4);
    // R4: reload kept at 160 -> masked expiry 320 cycles later
    wait_until(t + 4 * DIV_B * P - 1);
    check(pend_o == 0, "R4 pend before kept-reload expiry", pend_o, 0);
    @(negedge clk);
    check(pend_o == 1, "R4 R5 kept reload expiry", pend_o, 1);
    ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
    check(pend_o == 0, "R6 ack clears pend again", pend_o, 1);

    // scenario: both busy, then client 0 only
    while (!pend_o) @(negedge clk);
    busy_i = 2'b11;
    do_kick(t);
    expect_tick(t + DIV_B * P, "R3 both busy picks shorter");
    wait_until(t + 1);
    check(pend_o == 0, "R6 serviced tick clears pend", pend_o, 0);
    wait_until(t + DIV_B * P + 10);
    busy_i = 2'b01;
    expect_tick(t + 2 * DIV_B * P, "R3 change sampled at next tick");
    expect_tick(t + 2 * DIV_B * P + DIV_A * P, "R2 R3 client0 period");
    expect_tick(t + 2 * DIV_B * P + 2 * DIV_A * P, "R4 client0 idle tick");
    wait_until(t + 2 * DIV_B * P + DIV_A * P + 10);
    busy_i = 2'b00;
    wait_until(t + 2 * DIV_B * P + 2 * DIV_A * P + 5);
    check(masked_o == 1, "R4 masked after client0 done", masked_o, 1);
    check(tick_cnt_o == 9, "R9 tick count", tick_cnt_o, 9);

    // scenario: kick lands on the idle mask decision (R8)
    busy_i = 2'b10;
    do_kick(t);
    wait_until(t + 1);
    busy_i = 2'b00;
    expect_tick(t + DIV_B * P, "R8 tick on collision edge");
    expect_tick(t + DIV_B * P + P, "R7 R8 tick after colliding kick");
    wait_until(t + DIV_B * P - 1);
    kick_i = 1'b1; @(negedge clk); kick_i = 1'b0;
    check(masked_o == 0, "R8 kick wins over mask", masked_o, 0);
    wait_until(t + DIV_B * P + P + 3);
    check(masked_o == 1, "R4 masked after final tick", masked_o, 1);
    check(tick_cnt_o == 12, "R9 tick count", tick_cnt_o, 12);
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule